// File: doc/BRIEF.md
# Pedestal Subtract Zero Suppressor

This block receives 9-bit digitizer samples from up to 24 front-end cards. Each sample carries its card number and its channel number within the card. For every sample the block looks up a per-channel baseline offset and subtracts it. It then compares the difference with a per-channel cut level. Samples whose difference is above the cut are reduced to 8 bits and tagged with their card and channel. They are then queued in an output FIFO that feeds a valid/ready stream. Samples at or below the cut are dropped. Because every kept word carries its card and channel, a consumer can rebuild the full channel map by treating every missing channel as zero.

Two 8-bit tables, one for offsets and one for cut levels, are filled through a simple write port. Each table holds one entry per card and channel. An event-open input from the read-out controller marks the span in which sample data is flowing. While an event is open, or while a sample is still inside the block, table writes are discarded and a busy output is raised. When the output FIFO cannot take more words, the sample input is held off with a ready signal, so no sample is ever lost.

Top module: `pedzs_top`

## Requirements
- R1: After reset, out_valid is 0, busy is 0 and in_ready is 1, and every offset and cut entry reads as zero, so a nonzero sample passes unchanged.
- R2: The value field of a kept word equals the input sample minus the offset stored for that sample's card and channel.
- R3: A sample is kept only when (sample minus offset) is strictly greater than the cut level of its channel. A difference equal to the cut, or a negative difference, produces no output word.
- R4: A difference above 255 is output as 255.
- R5: Each output word is 18 bits: card index in bits 17:13, channel index in bits 12:8 and value in bits 7:0.
- R6: Kept words leave the block in the order their samples were accepted.
- R7: A table write changes only the entry addressed by its card and channel. All other entries keep their values.
- R8: busy is 1 whenever event_open is 1 or an accepted sample has not yet been resolved. A table write made while busy is 1 is discarded.
- R9: in_ready drops to 0 once the FIFO plus the pipeline stage hold FIFO_DEPTH words. While out_valid is 1 and out_ready is 0, out_data holds steady. No accepted sample is lost.
- R10: tbl_sel = 0 addresses the offset table and tbl_sel = 1 addresses the cut table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_open | input | 1 | High while an event's samples are being delivered |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_card | input | 5 | Card index of the sample |
| in_chan | input | 5 | Channel index of the sample |
| in_sample | input | 9 | Raw digitizer value |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 = offset table, 1 = cut table |
| tbl_card | input | 5 | Card index of the written entry |
| tbl_chan | input | 5 | Channel index of the written entry |
| tbl_data | input | 8 | Entry value |
| busy | output | 1 | Table writes are being discarded |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 18 | {card, channel, value} |

## Verification
Samples are sent against zero tables, against mixed offsets on several cards, and at exactly the cut, one above it and below the offset. These patterns separate a correct strict compare from a greater-or-equal compare and from a compare made on the clamped value. A sample far above its offset distinguishes clamping from wrap-around. Writes to neighbouring entries, and writes made during an open event, show whether the addressing and the discard rule are right. A stalled consumer fills the FIFO, which exposes any lost, reordered or changing output word.

// File: rtl/pedzs_pkg.sv
// Shared field widths and the output word layout of the zero suppressor.
// Assumes card and channel indices each fit in five bits.
package pedzs_pkg;
    localparam int CARD_W = 5;
    localparam int CHAN_W = 5;
    localparam int VAL_W  = 8;
    localparam int RAW_W  = 9;

    typedef struct packed {
        logic [CARD_W-1:0] card;
        logic [CHAN_W-1:0] chan;
        logic [VAL_W-1:0]  value;
    } pz_word_t;
endpackage

// File: rtl/pedzs_table.sv
// Per-card, per-channel 8-bit table with one write port and one
// combinational read port. Cleared to zero by reset. Assumes channel
// indices are always below N_CHAN; a card index at or above N_CARDS
// reads as zero and is never written.
module pedzs_table
    import pedzs_pkg::*;
#(
    parameter int N_CARDS = 24,
    parameter int N_CHAN  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CARD_W-1:0] wcard,
    input  logic [CHAN_W-1:0] wchan,
    input  logic [VAL_W-1:0]  wdata,
    input  logic [CARD_W-1:0] rcard,
    input  logic [CHAN_W-1:0] rchan,
    output logic [VAL_W-1:0]  rdata
);
    localparam int ENTRIES = N_CARDS * N_CHAN;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic [VAL_W-1:0] mem [ENTRIES];
    logic [IDX_W-1:0] w_idx, r_idx;
    logic             w_ok, r_ok;
    logic             armed;

    // Flatten card and channel into a table index.
    always_comb begin
        w_idx = IDX_W'(int'(wcard) * N_CHAN + int'(wchan));
        r_idx = IDX_W'(int'(rcard) * N_CHAN + int'(rchan));
        w_ok  = int'(wcard) < N_CARDS;
        r_ok  = int'(rcard) < N_CARDS;
    end

    // Clear on reset, otherwise store the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
        end else if (we && w_ok) begin
            mem[w_idx] <= wdata;
        end
    end

    // Read the addressed entry, zero outside the card range.
    always_comb rdata = r_ok ? mem[r_idx] : '0;

    // Marks that one clock has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R7
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(we) && $past(r_idx) == r_idx) |-> rdata == $past(rdata));
endmodule

// File: rtl/pedzs_calc.sv
// Offset subtraction, clamp to the output width and strict cut compare.
// Purely combinational. Assumes offset and cut are unsigned.
module pedzs_calc
    import pedzs_pkg::*;
(
    input  logic [RAW_W-1:0] sample,
    input  logic [VAL_W-1:0] offset,
    input  logic [VAL_W-1:0] cut,
    output logic [VAL_W-1:0] value,
    output logic             keep
);
    localparam int D_W = RAW_W + 1;

    logic signed [D_W-1:0] diff;

    // Signed difference, clamp and keep decision.
    always_comb begin
        diff  = $signed(D_W'(sample)) - $signed(D_W'(offset));
        keep  = diff > $signed(D_W'(cut));
        if (diff < 0)
            value = '0;
        else if (diff > $signed(D_W'({VAL_W{1'b1}})))
            value = {VAL_W{1'b1}};
        else
            value = diff[VAL_W-1:0];
    end

    // R3: a kept value exceeds a cut of at least zero, so it is never zero
    always_comb begin
        if (keep) begin
            keep_nonzero_chk: assert (value != '0);
        end
    end
endmodule

// File: rtl/pedzs_fifo.sv
// Output FIFO with show-ahead read. Assumes the writer never pushes
// while full; the occupancy count is exported for that purpose.
module pedzs_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       nonempty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_pop;

    // Pop only when there is something to pop.
    always_comb do_pop = pop && (count != '0);

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= (int'(wp) == DEPTH - 1) ? '0 : wp + 1'b1;
            if (do_pop) rp <= (int'(rp) == DEPTH - 1) ? '0 : rp + 1'b1;
            if (push && !do_pop)      count <= count + 1'b1;
            else if (!push && do_pop) count <= count - 1'b1;
        end
    end

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Head of queue is always visible.
    always_comb begin
        rdata    = mem[rp];
        nonempty = count != '0;
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !pop) |-> !push);
endmodule

// File: rtl/pedzs_top.sv
// Zero suppressor top: accepts tagged samples, reads offset and cut
// for the sample's card and channel, registers them one stage, then
// pushes kept words into the output FIFO. Assumes the writer of the
// tables respects busy; writes during busy are dropped here.
module pedzs_top
    import pedzs_pkg::*;
#(
    parameter int N_CARDS    = 24,
    parameter int N_CHAN     = 32,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          event_open,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [CARD_W-1:0]             in_card,
    input  logic [CHAN_W-1:0]             in_chan,
    input  logic [RAW_W-1:0]              in_sample,
    input  logic                          tbl_we,
    input  logic                          tbl_sel,
    input  logic [CARD_W-1:0]             tbl_card,
    input  logic [CHAN_W-1:0]             tbl_chan,
    input  logic [VAL_W-1:0]              tbl_data,
    output logic                          busy,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [$bits(pz_word_t)-1:0]   out_data
);
    localparam int WORD_W = $bits(pz_word_t);
    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);

    logic [VAL_W-1:0]  tbl_rd [2];
    logic              s1_v;
    logic [CARD_W-1:0] s1_card;
    logic [CHAN_W-1:0] s1_chan;
    logic [RAW_W-1:0]  s1_sample;
    logic [VAL_W-1:0]  s1_offset, s1_cut;
    logic [VAL_W-1:0]  calc_value;
    logic              calc_keep;
    logic              push;
    pz_word_t          push_word;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [CNT_W:0]    occupancy;
    logic              accept;

    // Busy while an event is open or a sample is in flight.
    always_comb busy = event_open || s1_v;

    // Table 0 holds offsets, table 1 holds cut levels.
    for (genvar g = 0; g < 2; g++) begin : g_tbl
        pedzs_table #(.N_CARDS(N_CARDS), .N_CHAN(N_CHAN)) u_tbl (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (tbl_we && !busy && (tbl_sel == 1'(g))),
            .wcard (tbl_card),
            .wchan (tbl_chan),
            .wdata (tbl_data),
            .rcard (in_card),
            .rchan (in_chan),
            .rdata (tbl_rd[g])
        );
    end

    // Hold off input when FIFO plus stage would reach the depth.
    always_comb begin
        occupancy = {1'b0, fifo_cnt} + {{CNT_W{1'b0}}, s1_v};
        in_ready  = occupancy < (CNT_W + 1)'(FIFO_DEPTH);
        accept    = in_valid && in_ready;
    end

    // Stage register: sample plus its looked-up table entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v      <= 1'b0;
            s1_card   <= '0;
            s1_chan   <= '0;
            s1_sample <= '0;
            s1_offset <= '0;
            s1_cut    <= '0;
        end else begin
            s1_v <= accept;
            if (accept) begin
                s1_card   <= in_card;
                s1_chan   <= in_chan;
                s1_sample <= in_sample;
                s1_offset <= tbl_rd[0];
                s1_cut    <= tbl_rd[1];
            end
        end
    end

    pedzs_calc u_calc (
        .sample (s1_sample),
        .offset (s1_offset),
        .cut    (s1_cut),
        .value  (calc_value),
        .keep   (calc_keep)
    );

    // Build the tagged word and decide on the push.
    always_comb begin
        push_word.card  = s1_card;
        push_word.chan  = s1_chan;
        push_word.value = calc_value;
        push            = s1_v && calc_keep;
    end

    pedzs_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .wdata    (push_word),
        .pop      (out_ready),
        .rdata    (out_data),
        .nonempty (out_valid),
        .count    (fifo_cnt)
    );

    // R9
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R9
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == CNT_W'(FIFO_DEPTH)) |-> !in_ready);

    // R8
    busy_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
endmodule

// File: tb/sim_pedzs_top.sv
// Directed bench for pedzs_top: one task per scenario, each checking
// its own results against a model built from the requirements.
module sim_pedzs_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        event_open = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [4:0]  in_card = '0;
    logic [4:0]  in_chan = '0;
    logic [8:0]  in_sample = '0;
    logic        tbl_we = 1'b0;
    logic        tbl_sel = 1'b0;
    logic [4:0]  tbl_card = '0;
    logic [4:0]  tbl_chan = '0;
    logic [7:0]  tbl_data = '0;
    logic        busy;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [17:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int ped [24][32];
    int thr [24][32];
    logic [17:0] expq [$];
    logic [17:0] rxq [$];

    always #10 clk = ~clk;

    pedzs_top u0 (
        .clk(clk), .rst_n(rst_n), .event_open(event_open),
        .in_valid(in_valid), .in_ready(in_ready), .in_card(in_card),
        .in_chan(in_chan), .in_sample(in_sample), .tbl_we(tbl_we),
        .tbl_sel(tbl_sel), .tbl_card(tbl_card), .tbl_chan(tbl_chan),
        .tbl_data(tbl_data), .busy(busy), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    // Collect words the consumer takes.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) rxq.push_back(out_data);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_ready(input bit r);
        @(posedge clk);
        #1 out_ready = r;
    endtask

    task automatic tbl_write(input bit sel, input int c, input int ch, input int d, input bit applies);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel; tbl_card = 5'(c); tbl_chan = 5'(ch); tbl_data = 8'(d);
        @(negedge clk);
        tbl_we = 1'b0;
        if (applies) begin
            if (sel) thr[c][ch] = d;
            else     ped[c][ch] = d;
        end
    endtask

    task automatic send(input int c, input int ch, input int s);
        int diff;
        @(negedge clk);
        in_valid = 1'b1; in_card = 5'(c); in_chan = 5'(ch); in_sample = 9'(s);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        diff = s - ped[c][ch];
        if (diff > thr[c][ch]) expq.push_back({5'(c), 5'(ch), 8'((diff > 255) ? 255 : diff)});
    endtask

    task automatic drain_and_compare(input string tag);
        repeat (30) @(negedge clk);
        check(rxq.size() == expq.size(), {tag, " word count"}, rxq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < rxq.size(); i++)
            check(rxq[i] === expq[i], tag, int'(rxq[i]), int'(expq[i]));
        expq.delete();
        rxq.delete();
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        send(3, 7, 5);
        send(3, 7, 0);
        send(23, 31, 1);
        drain_and_compare("R1 zero tables");
    endtask

    task automatic t_subtract();
        tbl_write(0, 0, 0, 20, 1);
        tbl_write(0, 12, 5, 100, 1);
        tbl_write(1, 12, 5, 10, 1);
        tbl_write(0, 23, 30, 7, 1);
        send(0, 0, 21);
        send(12, 5, 200);
        send(23, 30, 300);
        send(0, 0, 90);
        drain_and_compare("R2 R5 R6 R10 subtract");
    endtask

    task automatic t_cut_edge();
        tbl_write(0, 4, 9, 50, 1);
        tbl_write(1, 4, 9, 30, 1);
        send(4, 9, 80);
        send(4, 9, 81);
        send(4, 9, 40);
        send(4, 9, 79);
        send(4, 9, 200);
        drain_and_compare("R3 cut boundary");
    endtask

    task automatic t_clamp();
        tbl_write(0, 8, 1, 10, 1);
        tbl_write(1, 8, 1, 254, 1);
        send(8, 1, 511);
        send(8, 1, 265);
        send(8, 1, 264);
        drain_and_compare("R4 clamp");
    endtask

    task automatic t_neighbours();
        tbl_write(0, 1, 1, 60, 1);
        send(1, 1, 70);
        send(1, 0, 70);
        send(0, 1, 70);
        send(2, 1, 70);
        drain_and_compare("R7 neighbours");
    endtask

    task automatic t_busy_discard();
        @(negedge clk);
        event_open = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy during event", busy, 1);
        tbl_write(0, 2, 2, 100, 0);
        tbl_write(1, 2, 2, 200, 0);
        @(negedge clk);
        event_open = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R8 busy after event", busy, 0);
        send(2, 2, 50);
        drain_and_compare("R8 write discarded");
    endtask

    task automatic t_backpressure();
        set_ready(1'b0);
        for (int i = 0; i < 8; i++) send(5, i, 10 + i);
        check(in_ready == 1'b0, "R9 in_ready when full", in_ready, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid == 1'b1 && out_data == expq[0], "R9 head held",
                  int'(out_data), int'(expq[0]));
        end
        set_ready(1'b1);
        for (int i = 8; i < 12; i++) send(5, i, 10 + i);
        drain_and_compare("R9 R6 no loss in order");
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 24; c++)
            for (int ch = 0; ch < 32; ch++) begin
                ped[c][ch] = 0;
                thr[c][ch] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_subtract();
        t_cut_edge();
        t_clamp();
        t_neighbours();
        t_busy_discard();
        t_backpressure();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule